// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Generator

This block turns a one-cycle 256 Hz tick into periodic interrupt events. Software picks the rate through a 3-bit rate code held in a control register. Codes 1 to 6 divide the tick by 1, 4, 16, 64, 128 or 256. Each delivered event sets a sticky periodic flag, and that flag raises the periodic interrupt while the code selects a real rate.

A half-rate input makes the block drop every second divided event. This gives the in-between rates of 128, 32 and 8 Hz from codes 1, 2 and 3. A combined request output ORs the periodic interrupt with the carry and alarm requests from the rest of the clock block, for systems that wire only one interrupt line.

Top module: `prd_irq_gen`

## Requirements
- R1: After reset the periodic flag is 0, the rate code is 0, and the event output, periodic interrupt and (with carry and alarm low) combined request are all low.
- R2: A control write loads bits 6:4 of the write data as the rate code. Bit 7 of a write clears the flag when 0 and leaves it unchanged when 1.
- R3: With rate code 1, 2, 3, 4, 5 or 6, an event is delivered on every 1st, 4th, 16th, 64th, 128th or 256th tick respectively, counted from the last restart.
- R4: Rate codes 0 and 7 deliver no events, and the divider is held at its start phase.
- R5: An event is a one-cycle pulse that is high in the cycle after the clock edge that samples the tick which completes a division.
- R6: With half-rate on, the divided events alternate between delivered and dropped, starting with delivered after a restart.
- R7: Every control write restarts the divider phase and the half-rate alternation. A tick that arrives in the same cycle as a write is ignored.
- R8: The periodic interrupt is high exactly when the flag is set and the rate code is 1 to 6.
- R9: The combined request is the OR of the carry request, the alarm request and the periodic interrupt.
- R10: The flag is set by the same clock edge that launches an event pulse. It stays set until a write with bit 7 at 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick256 | input | 1 | One-cycle pulse at 256 Hz, never on two cycles in a row |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 4 ([7:4]) | Write data: bit 7 is the flag keep/clear bit, bits 6:4 are the rate code |
| halfRateEn | input | 1 | Drop every second divided event |
| carryReq | input | 1 | Carry interrupt request from the counter block |
| alarmReq | input | 1 | Alarm interrupt request from the compare block |
| periodicEvt | output | 1 | One-cycle event pulse |
| periodicFlag | output | 1 | Sticky periodic flag |
| periodicIrq | output | 1 | Periodic interrupt request |
| combinedIrq | output | 1 | OR of all three requests |

## Verification
The event pulse and the flag both change at the clock edge that samples the tick, so both are due one cycle after the tick is driven. A write changes the code and the flag at the edge that samples the write. The periodic and combined interrupts follow the registered flag and code with no further delay, and they also follow the carry and alarm inputs within the same cycle. The bench drives each stimulus just after a falling edge and compares every output 1 ns after the next rising edge, against a bench model advanced once per step. This puts each check in the first cycle where a result is due. Directed phases count delivered events over fixed tick runs to confirm each rate, the half-rate mode and the restart after a write.

// File: rtl/prd_irq_pkg.sv
package prd_irq_pkg;
  localparam int SEL_W = 3;
  localparam int CNT_W = 8;

  // strobes from control to divider datapath
  typedef struct packed {
    logic             restart;
    logic             enable;
    logic             halfMode;
    logic [CNT_W-1:0] limit;
  } divCtlT;

  function automatic logic codeValid(input logic [SEL_W-1:0] code);
    return (code >= SEL_W'(1)) && (code <= SEL_W'(6));
  endfunction

  // terminal count for each rate code: ticks per event minus one
  function automatic logic [CNT_W-1:0] rateLimit(input logic [SEL_W-1:0] code);
    logic [CNT_W-1:0] lim;
    case (code)
      SEL_W'(1): lim = CNT_W'(0);
      SEL_W'(2): lim = CNT_W'(3);
      SEL_W'(3): lim = CNT_W'(15);
      SEL_W'(4): lim = CNT_W'(63);
      SEL_W'(5): lim = CNT_W'(127);
      SEL_W'(6): lim = CNT_W'(255);
      default:   lim = CNT_W'(0);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/prd_ctrl.sv
module prd_ctrl
  import prd_irq_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [7:4]    wrData,
  input  logic          halfRateEn,
  input  logic          evtHit,
  output divCtlT        divCtl,
  output logic          flag,
  output logic          rateOk
);
  logic [SW-1:0] selQ;
  logic          flagQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      flagQ <= 1'b0;
    end else if (wrEn) begin
      selQ  <= wrData[6:4];
      flagQ <= flagQ & wrData[7];
    end else if (evtHit) begin
      flagQ <= 1'b1;
    end
  end

  always_comb begin
    divCtl.restart  = wrEn;
    divCtl.enable   = codeValid(selQ);
    divCtl.halfMode = halfRateEn;
    divCtl.limit    = rateLimit(selQ);
  end

  assign flag   = flagQ;
  assign rateOk = codeValid(selQ);

  assert_flag_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !$past(flagQ)) |-> $past(evtHit));
  assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[7]) |=> !flagQ);
endmodule

// File: rtl/prd_div.sv
module prd_div
  import prd_irq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   tick,
  input  divCtlT divCtl,
  output logic   evtHit,
  output logic   evtPulse
);
  logic [CW-1:0] cntQ;
  logic          skipQ;
  logic          evtQ;
  logic          rawHit;

  assign rawHit = tick && divCtl.enable && !divCtl.restart && (cntQ == divCtl.limit);
  assign evtHit = rawHit && !(divCtl.halfMode && skipQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      skipQ <= 1'b0;
      evtQ  <= 1'b0;
    end else begin
      evtQ <= evtHit;
      if (divCtl.restart || !divCtl.enable) begin
        cntQ  <= '0;
        skipQ <= 1'b0;
      end else if (tick) begin
        if (cntQ == divCtl.limit) begin
          cntQ  <= '0;
          skipQ <= divCtl.halfMode ? !skipQ : 1'b0;
        end else begin
          cntQ <= cntQ + CW'(1);
        end
      end
    end
  end

  assign evtPulse = evtQ;

  assert_evt_needs_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    evtQ |-> $past(tick));
  assert_evt_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    evtQ |=> !evtQ);
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    divCtl.enable |-> (cntQ <= divCtl.limit));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    divCtl.restart |=> (cntQ == '0 && !skipQ && !evtQ));
  assert_idle_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    !divCtl.enable |=> !evtQ);
endmodule

// File: rtl/prd_irq_gen.sv
module prd_irq_gen
  import prd_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick256,
  input  logic       ctrlWrEn,
  input  logic [7:4] ctrlWrData,
  input  logic       halfRateEn,
  input  logic       carryReq,
  input  logic       alarmReq,
  output logic       periodicEvt,
  output logic       periodicFlag,
  output logic       periodicIrq,
  output logic       combinedIrq
);
  divCtlT divCtl;
  logic   evtHit;
  logic   rateOk;

  prd_ctrl #(.SW(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(ctrlWrEn), .wrData(ctrlWrData),
    .halfRateEn(halfRateEn), .evtHit(evtHit), .divCtl(divCtl),
    .flag(periodicFlag), .rateOk(rateOk)
  );

  prd_div #(.CW(CNT_W)) uDiv (
    .clk(clk), .rstN(rstN), .tick(tick256), .divCtl(divCtl),
    .evtHit(evtHit), .evtPulse(periodicEvt)
  );

  assign periodicIrq = periodicFlag && rateOk;
  assign combinedIrq = carryReq || alarmReq || periodicIrq;

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    periodicIrq |-> periodicFlag);
  assert_comb_covers_R9: assert property (@(posedge clk) disable iff (!rstN)
    (periodicIrq || carryReq || alarmReq) |-> combinedIrq);
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    tick256 |=> !tick256);
endmodule

// File: tb/tb_prd_irq_gen.sv
`timescale 1ns/1ps
module tb_prd_irq_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick256 = 1'b0, ctrlWrEn = 1'b0, halfRateEn = 1'b0, carryReq = 1'b0, alarmReq = 1'b0;
  logic [7:4] ctrlWrData = 4'h0;
  logic periodicEvt, periodicFlag, periodicIrq, combinedIrq;

  int checks = 0, errors = 0, evCount = 0;
  bit done = 1'b0;
  // bench model
  int mCnt = 0;
  bit mSkip = 0, mFlag = 0, mEvt = 0;
  int mSel = 0;

  always #5 clk = ~clk;

  prd_irq_gen dut (
    .clk(clk), .rstN(rstN), .tick256(tick256), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .halfRateEn(halfRateEn), .carryReq(carryReq), .alarmReq(alarmReq),
    .periodicEvt(periodicEvt), .periodicFlag(periodicFlag),
    .periodicIrq(periodicIrq), .combinedIrq(combinedIrq)
  );

  function automatic int ticksPer(input int code);
    case (code)
      1: return 1;   2: return 4;   3: return 16;
      4: return 64;  5: return 128; 6: return 256;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkInt(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit t, input bit w, input logic [7:4] d, input bit h,
                      input bit c, input bit a);
    bit deliver;
    bit irqExp;
    @(negedge clk);
    tick256 = t; ctrlWrEn = w; ctrlWrData = d; halfRateEn = h; carryReq = c; alarmReq = a;
    deliver = 0;
    if (w) begin
      mCnt = 0; mSkip = 0; mFlag = mFlag & d[7]; mSel = int'(d[6:4]);
    end else if (ticksPer(mSel) == 0) begin
      mCnt = 0; mSkip = 0;
    end else if (t) begin
      if (mCnt == ticksPer(mSel) - 1) begin
        mCnt = 0;
        if (h) begin deliver = !mSkip; mSkip = !mSkip; end
        else begin deliver = 1; mSkip = 0; end
      end else mCnt++;
    end
    if (deliver) mFlag = 1;
    mEvt = deliver;
    @(posedge clk); #1;
    irqExp = mFlag && (ticksPer(mSel) != 0);
    if (periodicEvt === 1'b1) evCount++;
    chk(periodicEvt, mEvt, "R5 event pulse");
    chk(periodicFlag, mFlag, "R10 flag");
    chk(periodicIrq, irqExp, "R8 periodic irq");
    chk(combinedIrq, c | a | irqExp, "R9 combined irq");
  endtask

  task automatic wr(input int code, input bit keep, input bit h);
    step(0, 1, {keep, 3'(code)}, h, 0, 0);
  endtask

  task automatic ticks(input int n, input bit h);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 4'h0, h, 0, 0);
      step(0, 0, 4'h0, h, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(periodicEvt, 0, "R1 event after reset");
    chk(periodicFlag, 0, "R1 flag after reset");
    chk(periodicIrq, 0, "R1 irq after reset");
    chk(combinedIrq, 0, "R1 combined after reset");
    @(negedge clk); rstN = 1'b1;
    ticks(4, 0);
    chkInt(evCount, 0, "R1 code 0 after reset gives no events");

    // R3 rates
    for (int code = 1; code <= 6; code++) begin
      wr(code, 0, 0);
      evCount = 0;
      ticks(ticksPer(code) * 2, 0);
      chkInt(evCount, 2, $sformatf("R3 events for code %0d", code));
    end

    // R2 write bit 7 = 1 keeps flag, 0 clears it
    wr(1, 0, 0); ticks(1, 0);
    wr(1, 1, 0);
    chk(periodicFlag, 1, "R2 keep flag");
    wr(1, 0, 0);
    chk(periodicFlag, 0, "R2 clear flag");

    // R6 half rate: codes 1,2,3 give half the events
    for (int code = 1; code <= 3; code++) begin
      wr(code, 0, 1);
      evCount = 0;
      ticks(ticksPer(code) * 4, 1);
      chkInt(evCount, 2, $sformatf("R6 half-rate events for code %0d", code));
    end
    wr(1, 0, 1); evCount = 0;
    ticks(1, 1);
    chkInt(evCount, 1, "R6 first divided event delivered after restart");

    // R4 codes 0 and 7
    for (int k = 0; k < 2; k++) begin
      wr(k == 0 ? 0 : 7, 0, 0);
      evCount = 0;
      ticks(40, 0);
      chkInt(evCount, 0, "R4 no events on disabled code");
    end
    // R8 flag held but code 7 masks irq
    wr(1, 0, 0); ticks(1, 0);
    wr(7, 1, 0);
    chk(periodicFlag, 1, "R8 flag kept under code 7");
    chk(periodicIrq, 0, "R8 irq masked under code 7");

    // R7 tick coincident with write ignored; restart of phase
    wr(1, 0, 0); evCount = 0;
    step(1, 1, 4'b0001, 0, 0, 0);
    chkInt(evCount, 0, "R7 tick during write ignored");
    wr(2, 0, 0); ticks(2, 0);
    wr(2, 0, 0); evCount = 0;
    ticks(3, 0);
    chkInt(evCount, 0, "R7 phase restarted, no early event");
    ticks(1, 0);
    chkInt(evCount, 1, "R7 event on 4th tick after restart");

    // R9 combined with carry and alarm
    wr(0, 0, 0);
    step(0, 0, 4'h0, 0, 1, 0);
    step(0, 0, 4'h0, 0, 0, 1);

    // random phase
    begin
      bit lastT = 0;
      bit h = 0;
      for (int i = 0; i < 6000; i++) begin
        bit t, w, c, a;
        logic [7:4] d;
        t = !lastT && ($urandom % 3 == 0);
        w = ($urandom % 300 == 0);
        d = 4'($urandom);
        if (($urandom % 2) == 0) d[6:4] = 3'($urandom % 3 + 1);
        if (w) h = $urandom % 2;
        c = ($urandom % 8 == 0);
        a = ($urandom % 8 == 0);
        step(t, w, d, h, c, a);
        lastT = t;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule